// File: doc/BRIEF.md
# Source Address Match Table

This block keeps a small table of source addresses and checks received source addresses against it during receive-frame filtering. The table holds 24 short-address entries, each a 16-bit network identifier (PAN ID) paired with a 16-bit short address. The same bytes can also be read as 12 extended-address entries of 64 bits each. Extended entry n lies over short entries 2n and 2n+1.

A host writes the table bytes and two enable registers through a byte-wide write port. Each write names a byte address. The lookup side is a one-deep valid/ready stream. A request carries a mode bit, a PAN ID with a short address, and a 64-bit extended address. One clock after the request is accepted, the block presents a 24-bit hit mask, a found flag and the lowest hit index.

Back-pressure rules: `lk_ready` is high whenever no result is held, or the held result is being taken in the same cycle (`res_ready` high). A result stays valid, with all of its fields unchanged, until the cycle in which `res_valid` and `res_ready` are both high. A new request accepted in that same cycle replaces the result on the next clock.

Top module: `src_match_table`

## Requirements
- R1: After reset, `res_valid` is 0, `lk_ready` is 1, every table byte is 0 and both enable registers are 0. A lookup made straight after reset therefore returns mask 0, found 0 and index 0.
- R2: In short mode (`lk_ext`=0), result bit i is set only when short entry i is enabled, its PAN ID equals `lk_pan` and its short address equals `lk_short`. A mismatch in either field gives no hit.
- R3: Short entry i takes byte addresses 4i to 4i+3. The PAN ID sits low byte first at 4i and 4i+1. The short address sits low byte first at 4i+2 and 4i+3.
- R4: In extended mode (`lk_ext`=1), extended entry n is the 64-bit little-endian value in bytes 8n to 8n+7. It hits when it is enabled and equals `lk_xaddr`. A hit sets both result bits 2n and 2n+1.
- R5: Bit i of the short enable register is bit i%8 of the byte at address 96+i/8. Bit n of the extended enable register is bit n%8 of the byte at address 99+n/8. Writes to addresses 101 to 127 change nothing.
- R6: All hits are reported together. `res_found` is 1 exactly when the mask is non-zero. `res_index` is the lowest set bit of the mask, or 0 when the mask is empty.
- R7: A request accepted on one clock (`lk_valid` and `lk_ready` both high) gives `res_valid` on the next clock. While `res_valid` is high and `res_ready` is low, `lk_ready` is low and the result holds.
- R8: A host write in the same cycle as an accepted lookup does not change that lookup's result. It does change every later lookup.
- R9: Each mode uses only its own enable register. A disabled entry never hits, whatever its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 7 | Host byte address |
| wr_data | input | 8 | Host write data |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_ext | input | 1 | 1 for an extended-address lookup, 0 for short |
| lk_pan | input | 16 | PAN ID used in short mode |
| lk_short | input | 16 | Short address used in short mode |
| lk_xaddr | input | 64 | Extended address used in extended mode |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_mask | output | 24 | One bit per short-entry slot that hit |
| res_found | output | 1 | Any bit of the mask set |
| res_index | output | 5 | Lowest set bit of the mask |

## Verification
A host write and an accepted lookup can fall in the same cycle. The lookup must see the table as it was before that write. The bench provokes this in two ways. A directed step clears a byte of a matching entry while it looks up that entry. A random phase mixes writes, lookups and a stalling consumer. A behavioural model applies each write only after it has judged the lookup of the same edge, and every clock the model is compared against the outputs, including the held result and `lk_ready` during stalls.

// File: rtl/smt_pkg.sv
package smt_pkg;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_EXT   = 1'b1
  } smt_mode_e;

  // Byte address width: table bytes, then short enables, then extended enables.
  function automatic int smt_addr_width(input int num_short);
    int total;
    total = num_short * 4 + (num_short + 7) / 8 + (num_short / 2 + 7) / 8;
    return $clog2(total);
  endfunction

endpackage

// File: rtl/smt_store.sv
module smt_store #(
  parameter int NUM_SHORT = 24,
  parameter int AW        = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [7:0]              wr_data,
  output logic [NUM_SHORT*32-1:0] tbl,
  output logic [NUM_SHORT-1:0]    short_en,
  output logic [NUM_SHORT/2-1:0]  ext_en
);
  localparam int NUM_EXT   = NUM_SHORT / 2;
  localparam int TBL_BYTES = NUM_SHORT * 4;
  localparam int SEN_BASE  = TBL_BYTES;
  localparam int EEN_BASE  = SEN_BASE + (NUM_SHORT + 7) / 8;

  logic [7:0]           mem [TBL_BYTES];
  logic [NUM_SHORT-1:0] sen_q;
  logic [NUM_EXT-1:0]   een_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < TBL_BYTES; b++) mem[b] <= '0;
      sen_q <= '0;
      een_q <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < TBL_BYTES; b++)
        if (wr_addr == AW'(b)) mem[b] <= wr_data;
      for (int i = 0; i < NUM_SHORT; i++)
        if (wr_addr == AW'(SEN_BASE + i / 8)) sen_q[i] <= wr_data[i % 8];
      for (int n = 0; n < NUM_EXT; n++)
        if (wr_addr == AW'(EEN_BASE + n / 8)) een_q[n] <= wr_data[n % 8];
    end
  end

  // Byte b lands at bit 8b: little-endian fields fall out directly.
  genvar b;
  generate
    for (b = 0; b < TBL_BYTES; b++) begin : g_flat
      assign tbl[8*b +: 8] = mem[b];
    end
  endgenerate

  assign short_en = sen_q;
  assign ext_en   = een_q;

endmodule

// File: rtl/smt_compare.sv
module smt_compare #(
  parameter int NUM_SHORT = 24
) (
  input  logic [NUM_SHORT*32-1:0] tbl,
  input  logic [NUM_SHORT-1:0]    short_en,
  input  logic [NUM_SHORT/2-1:0]  ext_en,
  input  logic                    mode_ext,
  input  logic [15:0]             pan,
  input  logic [15:0]             sadr,
  input  logic [63:0]             xaddr,
  output logic [NUM_SHORT-1:0]    hit
);
  localparam int NUM_EXT = NUM_SHORT / 2;

  logic [NUM_SHORT-1:0] s_hit;
  logic [NUM_EXT-1:0]   e_hit;

  genvar i, n;
  generate
    for (i = 0; i < NUM_SHORT; i++) begin : g_short
      assign s_hit[i] = short_en[i]
                      && (tbl[32*i +: 16] == pan)
                      && (tbl[32*i + 16 +: 16] == sadr);
    end
    for (n = 0; n < NUM_EXT; n++) begin : g_ext
      assign e_hit[n] = ext_en[n] && (tbl[64*n +: 64] == xaddr);
      assign hit[2*n]     = mode_ext ? e_hit[n] : s_hit[2*n];
      assign hit[2*n + 1] = mode_ext ? e_hit[n] : s_hit[2*n + 1];
    end
  endgenerate

endmodule

// File: rtl/smt_lowest.sv
module smt_lowest #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vec[i]) idx = IW'(i);
  end

  assign any = |vec;

endmodule

// File: rtl/src_match_table.sv
module src_match_table
  import smt_pkg::*;
#(
  parameter int  NUM_SHORT = 24,
  localparam int IW        = $clog2(NUM_SHORT),
  localparam int AW        = smt_addr_width(NUM_SHORT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 lk_valid,
  output logic                 lk_ready,
  input  logic                 lk_ext,
  input  logic [15:0]          lk_pan,
  input  logic [15:0]          lk_short,
  input  logic [63:0]          lk_xaddr,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [NUM_SHORT-1:0] res_mask,
  output logic                 res_found,
  output logic [IW-1:0]        res_index
);
  localparam int NUM_EXT = NUM_SHORT / 2;

  logic [NUM_SHORT*32-1:0] tbl;
  logic [NUM_SHORT-1:0]    short_en;
  logic [NUM_EXT-1:0]      ext_en;
  logic [NUM_SHORT-1:0]    hit;
  logic [IW-1:0]           low_idx;
  logic                    any_hit;
  smt_mode_e               mode;

  logic                    valid_q;
  logic [NUM_SHORT-1:0]    mask_q;
  logic                    found_q;
  logic [IW-1:0]           idx_q;
  logic                    accept;

  assign mode = lk_ext ? MODE_EXT : MODE_SHORT;

  smt_store #(.NUM_SHORT(NUM_SHORT), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tbl(tbl), .short_en(short_en), .ext_en(ext_en)
  );

  smt_compare #(.NUM_SHORT(NUM_SHORT)) u_cmp (
    .tbl(tbl), .short_en(short_en), .ext_en(ext_en),
    .mode_ext(mode == MODE_EXT), .pan(lk_pan), .sadr(lk_short),
    .xaddr(lk_xaddr), .hit(hit)
  );

  smt_lowest #(.N(NUM_SHORT), .IW(IW)) u_low (
    .vec(hit), .idx(low_idx), .any(any_hit)
  );

  // Single result stage; drains and refills in the same cycle.
  assign lk_ready = !valid_q || res_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      found_q <= 1'b0;
      idx_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      mask_q  <= hit;
      found_q <= any_hit;
      idx_q   <= low_idx;
    end else if (res_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign res_valid = valid_q;
  assign res_mask  = mask_q;
  assign res_found = found_q;
  assign res_index = idx_q;

endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
  parameter int NUM_SHORT = 24,
  parameter int IW        = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_valid,
  input logic                 lk_ready,
  input logic                 lk_ext,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [NUM_SHORT-1:0] res_mask,
  input logic                 res_found,
  input logic [IW-1:0]        res_index
);
  localparam int NUM_EXT = NUM_SHORT / 2;

  logic               ext_q;
  logic [NUM_EXT-1:0] even_b, odd_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else if (lk_valid && lk_ready) ext_q <= lk_ext;
  end

  always_comb begin
    for (int n = 0; n < NUM_EXT; n++) begin
      even_b[n] = res_mask[2*n];
      odd_b[n]  = res_mask[2*n + 1];
    end
  end

  // R7: an accepted request yields a result on the next clock
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);

  // R7: a stalled result holds all its fields
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_mask)
                                   && $stable(res_index) && $stable(res_found)));

  // R7: with nothing held the request side is open
  p_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> lk_ready);

  // R6: found flag agrees with the mask
  p_found_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_found == (res_mask != '0)));

  // R6: index points at the lowest set bit
  p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_found) |-> (res_mask[res_index]
      && ((res_mask & ((NUM_SHORT'(1) << res_index) - NUM_SHORT'(1))) == '0)));

  // R4: extended hits always come in adjacent pairs
  p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ext_q) |-> (even_b == odd_b));

endmodule

bind src_match_table smt_checker #(.NUM_SHORT(NUM_SHORT), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_ext(lk_ext), .res_valid(res_valid), .res_ready(res_ready),
  .res_mask(res_mask), .res_found(res_found), .res_index(res_index)
);

// File: tb/tb_src_match_table.sv
module tb_src_match_table;
  localparam int CLK_P = 10;
  localparam int NS    = 24;
  localparam int NE    = NS / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic        lk_ext = 1'b0;
  logic [15:0] lk_pan = '0;
  logic [15:0] lk_short = '0;
  logic [63:0] lk_xaddr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [23:0] res_mask;
  logic        res_found;
  logic [4:0]  res_index;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  src_match_table #(.NUM_SHORT(NS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_ext(lk_ext), .lk_pan(lk_pan), .lk_short(lk_short),
    .lk_xaddr(lk_xaddr), .res_valid(res_valid), .res_ready(res_ready),
    .res_mask(res_mask), .res_found(res_found), .res_index(res_index)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_mem [NS*4];
  bit [NS-1:0] m_sen;
  bit [NE-1:0] m_een;
  bit          m_valid;
  logic [23:0] m_mask;
  int          m_idx;

  function automatic logic [23:0] model_mask(input bit ext, input logic [15:0] p,
                                             input logic [15:0] s, input logic [63:0] x);
    logic [23:0] r = '0;
    for (int i = 0; i < NS; i++) begin
      if (ext) begin
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++) v = v | (64'(m_mem[8*(i/2)+k]) << (8*k));
        r[i] = m_een[i/2] && (v == x);
      end else begin
        logic [15:0] pp = {m_mem[4*i+1], m_mem[4*i]};
        logic [15:0] ss = {m_mem[4*i+3], m_mem[4*i+2]};
        r[i] = m_sen[i] && (pp == p) && (ss == s);
      end
    end
    return r;
  endfunction

  function automatic int lowest(input logic [23:0] m);
    for (int i = 0; i < NS; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    if (a < NS*4) m_mem[a] = d;
    else if (a < NS*4 + 3) begin
      for (int k = 0; k < 8; k++) if ((a - NS*4)*8 + k < NS) m_sen[(a - NS*4)*8 + k] = d[k];
    end else if (a < NS*4 + 5) begin
      for (int k = 0; k < 8; k++) if ((a - NS*4 - 3)*8 + k < NE) m_een[(a - NS*4 - 3)*8 + k] = d[k];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NS*4; b++) m_mem[b] = '0;
      m_sen = '0; m_een = '0; m_valid = 0; m_mask = '0; m_idx = 0;
    end else begin
      // Lookup judged against the table before this edge's write (R8).
      if (lk_valid && (!m_valid || res_ready)) begin
        m_mask  = model_mask(lk_ext, lk_pan, lk_short, lk_xaddr);
        m_idx   = lowest(m_mask);
        m_valid = 1;
      end else if (res_ready) m_valid = 0;
      if (wr_en) model_write(int'(wr_addr), wr_data);
    end
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk(res_valid == m_valid, "R7 model res_valid", 64'(res_valid), 64'(m_valid));
      chk(lk_ready == (!m_valid || res_ready), "R7 model lk_ready", 64'(lk_ready),
          64'(!m_valid || res_ready));
      if (m_valid) begin
        chk(res_mask == m_mask, "R2 R4 R8 model res_mask", 64'(res_mask), 64'(m_mask));
        chk(res_index == 5'(m_idx), "R6 model res_index", 64'(res_index), 64'(m_idx));
        chk(res_found == (m_mask != 0), "R6 model res_found", 64'(res_found),
            64'(m_mask != 0));
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 7'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_req(input bit ext, input logic [15:0] p, input logic [15:0] s,
                         input logic [63:0] x);
    lk_valid = 1; lk_ext = ext; lk_pan = p; lk_short = s; lk_xaddr = x;
  endtask

  task automatic check_res(input logic [23:0] em, input int ei, input string tag);
    chk(res_valid == 1'b1, {tag, " res_valid"}, 64'(res_valid), 64'd1);
    chk(res_mask == em, {tag, " res_mask"}, 64'(res_mask), 64'(em));
    chk(res_index == 5'(ei), {tag, " res_index"}, 64'(res_index), 64'(ei));
    chk(res_found == (em != 0), {tag, " res_found"}, 64'(res_found), 64'(em != 0));
  endtask

  task automatic lookup(input bit ext, input logic [15:0] p, input logic [15:0] s,
                        input logic [63:0] x, input logic [23:0] em, input int ei,
                        input string tag);
    @(negedge clk);
    res_ready = 1; set_req(ext, p, s, x);
    @(negedge clk);
    lk_valid = 0;
    check_res(em, ei, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 reset res_valid", 64'(res_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(lk_ready == 1'b1, "R1 reset lk_ready", 64'(lk_ready), 64'd1);
    lookup(0, 16'h0, 16'h0, 64'h0, 24'h0, 0, "R1 empty table");

    // Short entry 3 written but not yet enabled.
    host_wr(12, 8'h34); host_wr(13, 8'h12); host_wr(14, 8'hCD); host_wr(15, 8'hAB);
    lookup(0, 16'h1234, 16'hABCD, 64'h0, 24'h0, 0, "R9 disabled short");
    host_wr(96, 8'h08);
    lookup(0, 16'h1234, 16'hABCD, 64'h0, 24'h000008, 3, "R2 R3 short hit");
    lookup(0, 16'h1234, 16'hABCC, 64'h0, 24'h0, 0, "R2 short addr differs");
    lookup(0, 16'h1235, 16'hABCD, 64'h0, 24'h0, 0, "R2 pan differs");

    // Duplicate in entry 17, enable via third short-enable byte.
    host_wr(68, 8'h34); host_wr(69, 8'h12); host_wr(70, 8'hCD); host_wr(71, 8'hAB);
    host_wr(98, 8'h02);
    lookup(0, 16'h1234, 16'hABCD, 64'h0, 24'h020008, 3, "R6 two hits");

    // Extended entry 5 over short entries 10 and 11.
    for (int k = 0; k < 8; k++) host_wr(40 + k, 8'(8'h10 + k));
    host_wr(99, 8'h20);
    lookup(1, 16'h0, 16'h0, 64'h1716151413121110, 24'h000C00, 10, "R4 ext pair");
    lookup(0, 16'h1110, 16'h1312, 64'h0, 24'h0, 0, "R9 short view of ext entry");
    lookup(1, 16'h0, 16'h0, 64'h1716151413121111, 24'h0, 0, "R4 ext mismatch");

    // Extended entry 9 enabled through the second extended-enable byte.
    for (int k = 0; k < 8; k++) host_wr(72 + k, 8'(8'hA0 + k));
    lookup(1, 16'h0, 16'h0, 64'hA7A6A5A4A3A2A1A0, 24'h0, 0, "R9 ext 9 disabled");
    host_wr(100, 8'h02);
    lookup(1, 16'h0, 16'h0, 64'hA7A6A5A4A3A2A1A0, 24'h0C0000, 18, "R5 ext enable byte 2");

    // Out-of-range writes change nothing.
    host_wr(101, 8'hFF); host_wr(127, 8'hFF);
    lookup(1, 16'h0, 16'h0, 64'h1716151413121110, 24'h000C00, 10, "R5 ignored writes ext");
    lookup(0, 16'h1234, 16'hABCD, 64'h0, 24'h020008, 3, "R5 ignored writes short");

    // Write and lookup in the same cycle.
    @(negedge clk);
    res_ready = 1; set_req(0, 16'h1234, 16'hABCD, 64'h0);
    wr_en = 1; wr_addr = 7'd14; wr_data = 8'h00;
    @(negedge clk);
    lk_valid = 0; wr_en = 0;
    check_res(24'h020008, 3, "R8 same-cycle write");
    lookup(0, 16'h1234, 16'hABCD, 64'h0, 24'h020000, 17, "R8 later lookup");

    // Back-pressure.
    @(negedge clk);
    res_ready = 0; set_req(0, 16'h1234, 16'hABCD, 64'h0);
    @(negedge clk);
    check_res(24'h020000, 17, "R7 stalled first");
    chk(lk_ready == 1'b0, "R7 stall lk_ready", 64'(lk_ready), 64'd0);
    set_req(1, 16'h0, 16'h0, 64'h1716151413121110);
    @(negedge clk);
    check_res(24'h020000, 17, "R7 held");
    chk(lk_ready == 1'b0, "R7 still stalled", 64'(lk_ready), 64'd0);
    res_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    check_res(24'h000C00, 10, "R7 refill on drain");

    // Random mix checked by the model every clock.
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      begin
        int j = $urandom_range(0, NS - 1);
        int n = j / 2;
        logic [63:0] x = '0;
        for (int k = 0; k < 8; k++) x = x | (64'(m_mem[8*n+k]) << (8*k));
        if ($urandom_range(0, 4) == 0) x[$urandom_range(0, 63)] ^= 1'b1;
        res_ready = ($urandom_range(0, 3) != 0);
        lk_valid  = $urandom_range(0, 1);
        lk_ext    = $urandom_range(0, 1);
        lk_pan    = {m_mem[4*j+1], m_mem[4*j]};
        lk_short  = {m_mem[4*j+3], m_mem[4*j+2]};
        if ($urandom_range(0, 4) == 0) lk_short = lk_short ^ 16'h0100;
        lk_xaddr  = x;
        wr_en     = ($urandom_range(0, 3) == 0);
        wr_addr   = 7'($urandom_range(0, 110));
        wr_data   = 8'($urandom_range(0, 255));
      end
    end
    @(negedge clk);
    lk_valid = 0; wr_en = 0; res_ready = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule